// File: doc/BRIEF.md
# Configuration Register Write-Protection Guard

This block sits between a simple register-bus slave port and the configuration registers of a serial controller. It holds seven protected configuration words, a few unprotected words, a protection mode register and a read-only status register. When protection is on, a write aimed at any protected word is dropped. The guard then raises a sticky violation flag and records the word offset of the register that the dropped write targeted.

The protection mode register is itself one of the protected words. A write to it takes effect only when bits 31:8 carry the fixed access key. A keyed write sets or clears the enable bit and also clears the violation flag. Software therefore turns protection on once, and later unlocks the registers or acknowledges a violation with a single keyed write. Reads return register contents through a combinational mux and have no side effects. The protected words also drive the controller directly on a flat configuration bus.

Top module: `wp_guard`

## Requirements
- R1: After reset, protection is disabled, the violation flag is clear, the source field is zero, and every register, protected or not, reads zero.
- R2: While protection is disabled, a write to any of the protected data words (word offsets 0x00 to 0x06) updates it, and a read returns the written value.
- R3: While protection is enabled, a write to a protected data word leaves its contents unchanged.
- R4: While protection is enabled, a write to any protected register sets the violation flag, which reads as bit 0 of the status register at word offset 0x21. The protected registers are offsets 0x00 to 0x06 and the mode register at 0x20. A correctly keyed write to the mode register is the one exception.
- R5: On a violation that occurs while the flag is clear, the status register's bits 23:8 capture the word offset of the targeted register.
- R6: While the flag is set, later violations change neither the flag nor the recorded source.
- R7: A write to the mode register (offset 0x20) whose bits 31:8 equal 0xA5C3E7 loads the enable bit from bit 0 and clears the flag and the source, whether protection is enabled or not. The mode register reads back the enable bit in bit 0 and zero elsewhere.
- R8: A mode-register write with any other key value changes neither the enable bit nor the flag. If protection is enabled at the time of the write, it counts as a violation with source 0x20. If protection is disabled, it has no effect at all.
- R9: Writes to the unprotected words (offsets 0x10 and 0x11) always take effect, whatever the protection state.
- R10: Reads have no side effects. A write to the status register changes nothing and is never a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | ADDR_W | Word offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| cfg_prot | output | 7*32 | Protected configuration words, offset 0 in the low word |
| cfg_open | output | NUM_OPEN*32 | Unprotected configuration words |

## Verification
Writes are applied to protected data words in both protection states, so dropped writes can be told apart from applied ones. The same writes go to unprotected words, which separates protection gating from plain address decode. Mode-register writes are tried with the correct key, with a wrong key while enabled and with a wrong key while disabled. These cases separate key checking from the enable-dependent violation rule. Repeated violations at different offsets, including the lowest offset 0 and the mode register itself, show that the first source is kept and that the flag and source come back after a keyed clear. Status writes and repeated status reads show that neither has a side effect.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int DATA_W    = 32;
    localparam int N_PROT    = 7;
    localparam int OPEN_BASE = 16;
    localparam int MODE_OFS  = 32;
    localparam int STAT_OFS  = 33;
    localparam int KEY_W     = 24;
    localparam int KEY_LSB   = 8;
    localparam int SRC_LSB   = 8;

    localparam logic [KEY_W-1:0] ACCESS_KEY = 24'hA5C3E7;

    typedef logic [DATA_W-1:0] word_t;

    // Decoded view of one bus address
    typedef struct packed {
        logic [N_PROT-1:0] prot_sel;
        logic              mode_sel;
        logic              stat_sel;
        logic              any_prot;
    } wp_hit_t;

    function automatic logic key_match(input logic [KEY_W-1:0] k);
        return k == ACCESS_KEY;
    endfunction

endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_OPEN = 2
) (
    input  logic [ADDR_W-1:0]   addr,
    output wp_hit_t             hit,
    output logic [NUM_OPEN-1:0] open_sel
);

    logic [N_PROT-1:0] prot_sel;

    genvar gi;
    generate
        for (gi = 0; gi < N_PROT; gi++) begin : g_prot
            assign prot_sel[gi] = (addr == ADDR_W'(gi));
        end
        for (gi = 0; gi < NUM_OPEN; gi++) begin : g_open
            assign open_sel[gi] = (addr == ADDR_W'(OPEN_BASE + gi));
        end
    endgenerate

    always_comb begin
        hit.prot_sel = prot_sel;
        hit.mode_sel = (addr == ADDR_W'(MODE_OFS));
        hit.stat_sel = (addr == ADDR_W'(STAT_OFS));
        hit.any_prot = (|prot_sel) | hit.mode_sel;
    end

endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wp_hit_t           hit,
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              en_bit,
    output logic              wp_en,
    output logic              wp_flag,
    output logic [SRC_W-1:0]  wp_src
);

    logic keyed_wr;
    logic violation;

    // A keyed mode write is the only legal write into the protected set
    // while enabled.
    assign keyed_wr  = wr_en & hit.mode_sel & key_match(key_in);
    assign violation = wr_en & wp_en & hit.any_prot & ~keyed_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_en   <= 1'b0;
            wp_flag <= 1'b0;
            wp_src  <= '0;
        end else if (keyed_wr) begin
            wp_en   <= en_bit;
            wp_flag <= 1'b0;
            wp_src  <= '0;
        end else if (violation && !wp_flag) begin
            wp_flag <= 1'b1;
            wp_src  <= SRC_W'(addr);
        end
    end

endmodule

// File: rtl/wp_reg_bank.sv
module wp_reg_bank
    import wp_guard_pkg::*;
#(
    parameter int NUM_OPEN = 2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic                           wp_en,
    input  wp_hit_t                        hit,
    input  logic [NUM_OPEN-1:0]            open_sel,
    input  word_t                          wdata,
    output logic [N_PROT-1:0][DATA_W-1:0]  prot_q,
    output logic [NUM_OPEN-1:0][DATA_W-1:0] open_q
);

    genvar gi;
    generate
        for (gi = 0; gi < N_PROT; gi++) begin : g_prot
            always_ff @(posedge clk) begin
                if (rst) begin
                    prot_q[gi] <= '0;
                end else if (wr_en && hit.prot_sel[gi] && !wp_en) begin
                    prot_q[gi] <= wdata;
                end
            end
        end
        for (gi = 0; gi < NUM_OPEN; gi++) begin : g_open
            always_ff @(posedge clk) begin
                if (rst) begin
                    open_q[gi] <= '0;
                end else if (wr_en && open_sel[gi]) begin
                    open_q[gi] <= wdata;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SRC_W    = 16,
    parameter int NUM_OPEN = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [31:0]                wdata,
    output logic [31:0]                rdata,
    output logic [7*32-1:0]            cfg_prot,
    output logic [NUM_OPEN*32-1:0]     cfg_open
);

    wp_hit_t                         hit;
    logic [NUM_OPEN-1:0]             open_sel;
    logic                            wp_en;
    logic                            wp_flag;
    logic [SRC_W-1:0]                wp_src;
    logic [N_PROT-1:0][DATA_W-1:0]   prot_q;
    logic [NUM_OPEN-1:0][DATA_W-1:0] open_q;

    wp_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_OPEN (NUM_OPEN)
    ) u_dec (
        .addr     (addr),
        .hit      (hit),
        .open_sel (open_sel)
    );

    wp_ctrl #(
        .ADDR_W (ADDR_W),
        .SRC_W  (SRC_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .hit     (hit),
        .addr    (addr),
        .key_in  (wdata[KEY_LSB +: KEY_W]),
        .en_bit  (wdata[0]),
        .wp_en   (wp_en),
        .wp_flag (wp_flag),
        .wp_src  (wp_src)
    );

    wp_reg_bank #(
        .NUM_OPEN (NUM_OPEN)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wp_en    (wp_en),
        .hit      (hit),
        .open_sel (open_sel),
        .wdata    (wdata),
        .prot_q   (prot_q),
        .open_q   (open_q)
    );

    assign cfg_prot = prot_q;
    assign cfg_open = open_q;

    // Read mux: one-hot selects, no state touched
    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_PROT; i++) begin
            if (hit.prot_sel[i]) rdata = prot_q[i];
        end
        for (int j = 0; j < NUM_OPEN; j++) begin
            if (open_sel[j]) rdata = open_q[j];
        end
        if (hit.mode_sel) rdata[0] = wp_en;
        if (hit.stat_sel) begin
            rdata[0]                = wp_flag;
            rdata[SRC_LSB +: SRC_W] = wp_src;
        end
    end

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SRC_W    = 16,
    parameter int NUM_OPEN = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [31:0]            wdata,
    input logic [7*32-1:0]        cfg_prot,
    input logic [NUM_OPEN*32-1:0] cfg_open,
    input logic                   wp_en,
    input logic                   wp_flag,
    input logic [SRC_W-1:0]       wp_src
);

    logic mode_hit, key_ok, kw, prot_hit;
    assign mode_hit = (addr == ADDR_W'(MODE_OFS));
    assign key_ok   = (wdata[31:8] == 24'hA5C3E7);
    assign kw       = wr_en && mode_hit && key_ok;
    assign prot_hit = (addr < ADDR_W'(N_PROT)) || mode_hit;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!wp_en && !wp_flag && wp_src == '0 && cfg_prot == '0 && cfg_open == '0));

    a_r2_open_prot_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wp_en && addr == '0) |=> cfg_prot[31:0] == $past(wdata));

    a_r3_blocked_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp_en && addr < ADDR_W'(N_PROT)) |=> $stable(cfg_prot));

    a_r4_flag_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp_en && prot_hit && !kw) |=> wp_flag);

    a_r5_src_capture: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp_en && prot_hit && !kw && !wp_flag) |=> wp_src == SRC_W'($past(addr)));

    a_r6_src_sticky: assert property (@(posedge clk) disable iff (rst)
        (wp_flag && !kw) |=> (wp_flag && $stable(wp_src)));

    a_r7_key_apply: assert property (@(posedge clk) disable iff (rst)
        kw |=> (!wp_flag && wp_en == $past(wdata[0])));

    a_r8_badkey_keeps_en: assert property (@(posedge clk) disable iff (rst)
        (wr_en && mode_hit && !key_ok) |=> $stable(wp_en));

    a_r9_open_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(OPEN_BASE)) |=> cfg_open[31:0] == $past(wdata));

endmodule

bind wp_guard wp_guard_chk #(
    .ADDR_W   (ADDR_W),
    .SRC_W    (SRC_W),
    .NUM_OPEN (NUM_OPEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .cfg_prot (cfg_prot),
    .cfg_open (cfg_open),
    .wp_en    (wp_en),
    .wp_flag  (wp_flag),
    .wp_src   (wp_src)
);

// File: tb/wp_guard_tb.sv
module wp_guard_tb;

    localparam int ADDR_W   = 8;
    localparam int NUM_OPEN = 2;
    localparam int N_VEC    = 51;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   wr_en = 1'b0;
    logic [ADDR_W-1:0]      addr = '0;
    logic [31:0]            wdata = '0;
    logic [31:0]            rdata;
    logic [7*32-1:0]        cfg_prot;
    logic [NUM_OPEN*32-1:0] cfg_open;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    wp_guard #(.ADDR_W(ADDR_W), .SRC_W(16), .NUM_OPEN(NUM_OPEN)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .cfg_prot(cfg_prot), .cfg_open(cfg_open)
    );

    // {is_read, addr, data (write value or expected read), requirement}
    // Key 0xA5C3E7 in bits 31:8; mode at 0x20, status at 0x21 (flag bit 0, source 23:8)
    localparam logic [44:0] VEC [N_VEC] = '{
        {1'b1, 8'h00, 32'h00000000, 4'd1},   // R1 reset values
        {1'b1, 8'h20, 32'h00000000, 4'd1},
        {1'b1, 8'h21, 32'h00000000, 4'd1},
        {1'b1, 8'h11, 32'h00000000, 4'd1},
        {1'b0, 8'h00, 32'h11111111, 4'd2},   // R2 unprotected state
        {1'b1, 8'h00, 32'h11111111, 4'd2},
        {1'b0, 8'h06, 32'h66666666, 4'd2},
        {1'b1, 8'h06, 32'h66666666, 4'd2},
        {1'b0, 8'h10, 32'hAAAA5555, 4'd9},   // R9 open word
        {1'b1, 8'h10, 32'hAAAA5555, 4'd9},
        {1'b0, 8'h20, 32'hA5C3E701, 4'd7},   // R7 enable with key
        {1'b1, 8'h20, 32'h00000001, 4'd7},
        {1'b1, 8'h21, 32'h00000000, 4'd7},
        {1'b0, 8'h03, 32'hDEADBEEF, 4'd3},   // R3 blocked
        {1'b1, 8'h03, 32'h00000000, 4'd3},
        {1'b1, 8'h21, 32'h00000301, 4'd5},   // R4 R5 flag and source 0x03
        {1'b0, 8'h05, 32'h00000001, 4'd6},   // R6 second violation
        {1'b1, 8'h05, 32'h00000000, 4'd3},
        {1'b1, 8'h21, 32'h00000301, 4'd6},
        {1'b0, 8'h11, 32'h12345678, 4'd9},   // R9 while enabled
        {1'b1, 8'h11, 32'h12345678, 4'd9},
        {1'b0, 8'h00, 32'h00000000, 4'd3},
        {1'b1, 8'h00, 32'h11111111, 4'd3},
        {1'b0, 8'h20, 32'h12345600, 4'd8},   // R8 wrong key, enabled, flag set
        {1'b1, 8'h20, 32'h00000001, 4'd8},
        {1'b1, 8'h21, 32'h00000301, 4'd8},
        {1'b0, 8'h20, 32'hA5C3E701, 4'd7},   // R7 keyed clear, stays enabled
        {1'b1, 8'h21, 32'h00000000, 4'd7},
        {1'b1, 8'h20, 32'h00000001, 4'd7},
        {1'b0, 8'h20, 32'h00000000, 4'd8},   // R8 wrong key is a violation
        {1'b1, 8'h20, 32'h00000001, 4'd8},
        {1'b1, 8'h21, 32'h00002001, 4'd8},
        {1'b0, 8'h21, 32'hFFFFFFFF, 4'd10},  // R10 status write ignored
        {1'b1, 8'h21, 32'h00002001, 4'd10},
        {1'b0, 8'h20, 32'hA5C3E700, 4'd7},   // R7 keyed disable
        {1'b1, 8'h20, 32'h00000000, 4'd7},
        {1'b1, 8'h21, 32'h00000000, 4'd7},
        {1'b0, 8'h20, 32'h00000001, 4'd8},   // R8 wrong key while disabled
        {1'b1, 8'h20, 32'h00000000, 4'd8},
        {1'b1, 8'h21, 32'h00000000, 4'd8},
        {1'b0, 8'h03, 32'hCAFEF00D, 4'd2},
        {1'b1, 8'h03, 32'hCAFEF00D, 4'd2},
        {1'b0, 8'h20, 32'hA5C3E701, 4'd7},
        {1'b0, 8'h21, 32'hFFFFFFFF, 4'd10},  // R10 not a violation
        {1'b1, 8'h21, 32'h00000000, 4'd10},
        {1'b1, 8'h21, 32'h00000000, 4'd10},
        {1'b0, 8'h06, 32'h00000000, 4'd5},   // R5 top protected offset
        {1'b1, 8'h21, 32'h00000601, 4'd5},
        {1'b0, 8'h00, 32'h00000000, 4'd6},
        {1'b1, 8'h21, 32'h00000601, 4'd6},
        {1'b1, 8'h06, 32'h66666666, 4'd3}
    };

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_read(input logic [7:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        addr = a;
        #1;
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL R%0d addr=%h actual=%h expected=%h", req, a, rdata, exp);
        end
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            if (VEC[i][44])
                check_read(VEC[i][43:36], VEC[i][35:4], int'(VEC[i][3:0]));
            else
                do_write(VEC[i][43:36], VEC[i][35:4]);
        end

        // R5: violation at offset zero records source 0
        do_write(8'h20, 32'hA5C3E701);
        do_write(8'h00, 32'h0BADF00D);
        check_read(8'h21, 32'h00000001, 5);
        check_read(8'h00, 32'h11111111, 3);

        // R1: reset in the middle of a run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_read(8'h00, 32'h0, 1);
        check_read(8'h03, 32'h0, 1);
        check_read(8'h06, 32'h0, 1);
        check_read(8'h10, 32'h0, 1);
        check_read(8'h11, 32'h0, 1);
        check_read(8'h20, 32'h0, 1);
        check_read(8'h21, 32'h0, 1);

        // R2: protection is off after reset
        do_write(8'h01, 32'h01020304);
        check_read(8'h01, 32'h01020304, 2);
        check_read(8'h21, 32'h0, 2);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

endmodule